// File: doc/BRIEF.md
# JTAG Indirect Register Access Port

This block is the back end of a JTAG test access port. It lets an external debugger reach a sparse 14-bit register bus through a narrow scan interface. A 5-bit instruction register picks the active data register. The choices are an 8-bit power control register, an 8-bit power status sample, a 32-bit identification code, a 1-bit bypass cell, and an access pair. The access pair is an 8-bit address/command register followed by a 32-bit data register. The debugger scans a command holding a 7-bit compact address and a write flag. The block remaps the compact address piecewise into a word-aligned bus offset. It then issues a read or write on a simple request/response bus.

While a selected access pair is active, successive DR scans alternate between the command register and the data register. Each Update-IR that selects the pair starts again at the command register. Capturing the command register reports two flags: busy while a bus transfer is outstanding, and error. Error is raised for an unmapped address or for an access started while busy. A read result waits in a holding register and is delivered at the next capture of the data register.

The bus side is a valid/ready request channel. Once `req_valid` is high, the request stays asserted and its address, direction and write data stay stable until `req_ready` is sampled high. Responses come back as a single-cycle `rsp_valid` pulse with no back-pressure, and there is at most one transfer outstanding. Everything runs on `tck`. `tdo` is combinational from the shift-register LSB during Shift-DR and Shift-IR, and is 0 otherwise.

Top module: `jtag_reg_access`

## Requirements
- R1: The TAP controller follows the standard 16-state JTAG machine. `trst_n` low, or five TMS-high clocks, brings it to Test-Logic-Reset. That state loads the IDCODE instruction (0x1E) and clears the power control register to 0.
- R2: The instruction register is 5 bits wide and captures the pattern 5'b00001. Code 0x08 selects power control, 0x09 power status, 0x1C the access pair and 0x1E IDCODE. 0x1F and every other code select bypass.
- R3: Capturing IDCODE loads 0x120034E5, which is shifted out LSB first.
- R4: Bypass is a single cell that captures 0, so TDI reappears on TDO one clock later.
- R5: After an Update-IR selecting 0x1C, DR scans alternate: first the 8-bit command register, then the 32-bit data register. In the command register, bit 0 is the write flag (1 = write) and bits 7:1 are the compact address. Its capture value has busy in bit 1, error in bit 0 and zeros above.
- R6: Compact address a maps to bus offset as follows.
  - 0x00–0x1F: a×4.
  - 0x20–0x3F: 0x1000 | a[2:0]<<2 | a[4:3]<<7.
  - 0x40–0x4F: 0x2000 | a[3:0]<<2.
  - 0x58–0x5F: 0x3000 | a[3:0]<<2.
  - 0x60: 0x3F00.
  - 0x68–0x7F: 0x3F80 | a[4:0]<<2.
- R7: A command update with an address outside the map sets error and issues no bus request.
- R8: A command update with the write flag at 0 and a mapped address issues one bus read. The response data is returned by the next capture of the data register.
- R9: A command update with the write flag at 1 issues nothing. Each later data-register update issues one bus write of the shifted 32-bit value to that address.
- R10: Busy is high from the issue of a request until its response. A command or write-data update arriving while busy is ignored and sets error. Error is cleared by the next command update that is neither ignored nor unmapped.
- R11: The request is held with stable address, direction and data until `req_ready` is high. The response is a one-cycle `rsp_valid` that cannot be stalled.
- R12: A power control update drives the shifted 8 bits onto `pwr_ctl_o`, and its capture returns the current value. A power status capture returns `pwr_stat_i`, and its update changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; clocks all logic |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, valid in shift states |
| pwr_ctl_o | output | 8 | Power control register contents |
| pwr_stat_i | input | 8 | Power status sampled on capture |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus request accepted |
| req_write | output | 1 | 1 = write request, 0 = read |
| req_addr | output | 14 | Word-aligned bus offset |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | One-cycle response strobe |
| rsp_rdata | input | 32 | Read data, valid with rsp_valid |

## Verification
The bench sweeps all 128 compact addresses with varied response latencies. For each mapped address it checks the bus offset and the returned read data. For each hole it checks that no request appears and that error is set. A wrong boundary in the remap (0x50–0x57, 0x61–0x67) would either issue a phantom request or put data at a wrong offset. The busy cases start a new command and a new write during a slow response. A design that does not ignore these would issue a second request or overwrite the pending write data, and one that does not clear error would leave bit 0 stuck. A stalled `req_ready` catches a request that drops or changes before it is accepted. The command/data alternation and the reload of IDCODE on Test-Logic-Reset are checked through the shifted bit patterns.

// File: rtl/jtag_acc_pkg.sv
package jtag_acc_pkg;

  localparam int CADDR_W = 7;
  localparam int BUS_AW  = 14;
  localparam int IR_W    = 5;

  localparam logic [IR_W-1:0] IR_PWC  = 5'h08;
  localparam logic [IR_W-1:0] IR_PWS  = 5'h09;
  localparam logic [IR_W-1:0] IR_ACC  = 5'h1C;
  localparam logic [IR_W-1:0] IR_IDC  = 5'h1E;
  localparam logic [IR_W-1:0] IR_BYP  = 5'h1F;
  localparam logic [IR_W-1:0] IR_CAPT = 5'b00001;

  typedef enum logic [3:0] {
    TS_TLR, TS_RTI, TS_SELDR, TS_CAPDR, TS_SHDR, TS_EX1DR, TS_PADR, TS_EX2DR,
    TS_UPDR, TS_SELIR, TS_CAPIR, TS_SHIR, TS_EX1IR, TS_PAIR, TS_EX2IR, TS_UPIR
  } tap_state_e;

  typedef enum logic [2:0] {
    DS_BYP, DS_IDC, DS_PWC, DS_PWS, DS_CMD, DS_DATA
  } dr_sel_e;

  // Returns {hit, offset}; offset is word aligned.
  function automatic logic [BUS_AW:0] remap(input logic [CADDR_W-1:0] a);
    logic [BUS_AW-1:0] o;
    logic hit;
    hit = 1'b1;
    o   = '0;
    if (a[6:5] == 2'b00)
      o = {7'b0, a[4:0], 2'b00};
    else if (a[6:5] == 2'b01)
      o = {2'b01, 3'b000, a[4:3], 2'b00, a[2:0], 2'b00};
    else if (a[6:4] == 3'b100)
      o = {2'b10, 6'b0, a[3:0], 2'b00};
    else if (a[6:3] == 4'b1011)
      o = {2'b11, 6'b0, a[3:0], 2'b00};
    else if (a == 7'h60)
      o = 14'h3F00;
    else if (a[6:5] == 2'b11 && a[4:3] != 2'b00)
      o = {7'h7F, a[4:0], 2'b00};
    else
      hit = 1'b0;
    return {hit, o};
  endfunction

endpackage

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_acc_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    unique case (state)
      TS_TLR:   nxt = tms ? TS_TLR   : TS_RTI;
      TS_RTI:   nxt = tms ? TS_SELDR : TS_RTI;
      TS_SELDR: nxt = tms ? TS_SELIR : TS_CAPDR;
      TS_CAPDR: nxt = tms ? TS_EX1DR : TS_SHDR;
      TS_SHDR:  nxt = tms ? TS_EX1DR : TS_SHDR;
      TS_EX1DR: nxt = tms ? TS_UPDR  : TS_PADR;
      TS_PADR:  nxt = tms ? TS_EX2DR : TS_PADR;
      TS_EX2DR: nxt = tms ? TS_UPDR  : TS_SHDR;
      TS_UPDR:  nxt = tms ? TS_SELDR : TS_RTI;
      TS_SELIR: nxt = tms ? TS_TLR   : TS_CAPIR;
      TS_CAPIR: nxt = tms ? TS_EX1IR : TS_SHIR;
      TS_SHIR:  nxt = tms ? TS_EX1IR : TS_SHIR;
      TS_EX1IR: nxt = tms ? TS_UPIR  : TS_PAIR;
      TS_PAIR:  nxt = tms ? TS_EX2IR : TS_PAIR;
      TS_EX2IR: nxt = tms ? TS_UPIR  : TS_SHIR;
      TS_UPIR:  nxt = tms ? TS_SELDR : TS_RTI;
      default:  nxt = TS_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TS_TLR;
    else         state <= nxt;
  end

  // R1: with TMS high, reset state is never left
  a_r1_tlr_sticky: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_TLR && tms) |=> (state == TS_TLR));

  // R1: from Select-IR, TMS high reaches reset
  a_r1_selir_exit: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_SELIR && tms) |=> (state == TS_TLR));

endmodule

// File: rtl/jtag_ir_unit.sv
module jtag_ir_unit
  import jtag_acc_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_e state,
  output logic       ir_lsb,
  output dr_sel_e    sel
);

  logic [IR_W-1:0] ir_sh;
  logic [IR_W-1:0] ir_q;
  logic            data_phase;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh      <= IR_CAPT;
      ir_q       <= IR_IDC;
      data_phase <= 1'b0;
    end else begin
      unique case (state)
        TS_TLR: begin
          ir_q       <= IR_IDC;
          data_phase <= 1'b0;
        end
        TS_CAPIR: ir_sh <= IR_CAPT;
        TS_SHIR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        TS_UPIR: begin
          ir_q       <= ir_sh;
          data_phase <= 1'b0;
        end
        TS_UPDR: if (ir_q == IR_ACC) data_phase <= ~data_phase;
        default: ;
      endcase
    end
  end

  assign ir_lsb = ir_sh[0];

  always_comb begin
    unique case (ir_q)
      IR_PWC:  sel = DS_PWC;
      IR_PWS:  sel = DS_PWS;
      IR_ACC:  sel = data_phase ? DS_DATA : DS_CMD;
      IR_IDC:  sel = DS_IDC;
      default: sel = DS_BYP;
    endcase
  end

  // R1: reset state leaves the IDCODE instruction loaded
  a_r1_tlr_idcode: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_TLR) |=> (ir_q == IR_IDC));

  // R5: a new instruction always restarts the pair at the command register
  a_r5_phase_restart: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_UPIR) |=> (sel != DS_DATA));

endmodule

// File: rtl/jtag_acc_engine.sv
module jtag_acc_engine
  import jtag_acc_pkg::*;
#(
  parameter int DR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_cmd,
  input  logic              upd_data,
  input  logic [7:0]        cmd_in,
  input  logic [DR_W-1:0]   data_in,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [BUS_AW-1:0] req_addr,
  output logic [DR_W-1:0]   req_wdata,
  input  logic              rsp_valid,
  input  logic [DR_W-1:0]   rsp_rdata,
  output logic              busy,
  output logic              err,
  output logic [DR_W-1:0]   rd_hold
);

  logic [BUS_AW:0]   map;
  logic              tgt_ok;
  logic              tgt_wr;
  logic [BUS_AW-1:0] tgt_addr;

  assign map = remap(cmd_in[7:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      busy      <= 1'b0;
      err       <= 1'b0;
      rd_hold   <= '0;
      tgt_ok    <= 1'b0;
      tgt_wr    <= 1'b0;
      tgt_addr  <= '0;
    end else begin
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (busy && rsp_valid) begin
        busy <= 1'b0;
        if (!req_write) rd_hold <= rsp_rdata;
      end
      if (upd_cmd) begin
        if (busy) begin
          err <= 1'b1;
        end else begin
          tgt_ok   <= map[BUS_AW];
          tgt_wr   <= cmd_in[0];
          tgt_addr <= map[BUS_AW-1:0];
          err      <= ~map[BUS_AW];
          if (map[BUS_AW] && !cmd_in[0]) begin
            req_valid <= 1'b1;
            req_write <= 1'b0;
            req_addr  <= map[BUS_AW-1:0];
            busy      <= 1'b1;
          end
        end
      end else if (upd_data && tgt_ok && tgt_wr) begin
        if (busy) begin
          err <= 1'b1;
        end else begin
          req_valid <= 1'b1;
          req_write <= 1'b1;
          req_addr  <= tgt_addr;
          req_wdata <= data_in;
          busy      <= 1'b1;
        end
      end
    end
  end

  // R11: a pending request holds still until accepted
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_write) && $stable(req_wdata)));

  // R10: an outstanding request always reads as busy
  a_r10_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

  // R10: an access arriving while busy raises error and issues nothing new
  a_r10_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (upd_cmd || (upd_data && tgt_ok && tgt_wr))) |=> (err && !$rose(req_valid)));

  // R7: an unmapped command raises error and requests nothing
  a_r7_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_cmd && !busy && !map[BUS_AW]) |=> (err && !req_valid));

  // R6: every bus offset is word aligned
  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[1:0] == 2'b00));

endmodule

// File: rtl/jtag_reg_access.sv
module jtag_reg_access
  import jtag_acc_pkg::*;
#(
  parameter int          DR_W   = 32,
  parameter int          PWR_W  = 8,
  parameter logic [31:0] IDCODE = 32'h120034E5
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic [PWR_W-1:0]  pwr_ctl_o,
  input  logic [PWR_W-1:0]  pwr_stat_i,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [BUS_AW-1:0] req_addr,
  output logic [DR_W-1:0]   req_wdata,
  input  logic              rsp_valid,
  input  logic [DR_W-1:0]   rsp_rdata
);

  localparam int LEN_W = $clog2(DR_W);
  localparam int CMD_W = 8;

  tap_state_e          state;
  dr_sel_e             sel;
  logic                ir_lsb;
  logic [DR_W-1:0]     dr_sh;
  logic [DR_W-1:0]     dr_nx;
  logic [DR_W-1:0]     cap;
  logic [LEN_W-1:0]    top_bit;
  logic [PWR_W-1:0]    pwr_ctl_q;
  logic                busy;
  logic                err;
  logic [DR_W-1:0]     rd_hold;
  logic                upd_cmd;
  logic                upd_data;

  jtag_tap_ctrl u_tap (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  jtag_ir_unit u_ir (
    .tck    (tck),
    .trst_n (trst_n),
    .tdi    (tdi),
    .state  (state),
    .ir_lsb (ir_lsb),
    .sel    (sel)
  );

  always_comb begin
    unique case (sel)
      DS_IDC, DS_DATA: top_bit = LEN_W'(DR_W - 1);
      DS_PWC, DS_PWS:  top_bit = LEN_W'(PWR_W - 1);
      DS_CMD:          top_bit = LEN_W'(CMD_W - 1);
      default:         top_bit = '0;
    endcase
  end

  always_comb begin
    unique case (sel)
      DS_IDC:  cap = DR_W'(IDCODE);
      DS_PWC:  cap = DR_W'(pwr_ctl_q);
      DS_PWS:  cap = DR_W'(pwr_stat_i);
      DS_CMD:  cap = DR_W'({busy, err});
      DS_DATA: cap = rd_hold;
      default: cap = '0;
    endcase
  end

  always_comb begin
    dr_nx          = dr_sh >> 1;
    dr_nx[top_bit] = tdi;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      dr_sh     <= '0;
      pwr_ctl_q <= '0;
    end else begin
      unique case (state)
        TS_TLR:   pwr_ctl_q <= '0;
        TS_CAPDR: dr_sh <= cap;
        TS_SHDR:  dr_sh <= dr_nx;
        TS_UPDR:  if (sel == DS_PWC) pwr_ctl_q <= dr_sh[PWR_W-1:0];
        default:  ;
      endcase
    end
  end

  assign upd_cmd  = (state == TS_UPDR) && (sel == DS_CMD);
  assign upd_data = (state == TS_UPDR) && (sel == DS_DATA);

  jtag_acc_engine #(.DR_W(DR_W)) u_eng (
    .clk       (tck),
    .rst_n     (trst_n),
    .upd_cmd   (upd_cmd),
    .upd_data  (upd_data),
    .cmd_in    (dr_sh[CMD_W-1:0]),
    .data_in   (dr_sh),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .busy      (busy),
    .err       (err),
    .rd_hold   (rd_hold)
  );

  assign pwr_ctl_o = pwr_ctl_q;
  assign tdo = (state == TS_SHDR) ? dr_sh[0] : (state == TS_SHIR) ? ir_lsb : 1'b0;

  // R12: power control changes only on its own update or on TAP reset
  a_r12_pwc_only_on_update: assert property (@(posedge tck) disable iff (!trst_n)
    !((state == TS_UPDR && sel == DS_PWC) || state == TS_TLR) |=> $stable(pwr_ctl_o));

  // R5: command and data updates never coincide
  a_r5_single_update: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({upd_cmd, upd_data}));

endmodule

// File: tb/test_jtag_reg_access.sv
module test_jtag_reg_access;

  logic        tck = 1'b0;
  logic        trst_n = 1'b0;
  logic        tms = 1'b1;
  logic        tdi = 1'b0;
  logic        tdo;
  logic [7:0]  pwr_ctl_o;
  logic [7:0]  pwr_stat_i = 8'h00;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic        req_write;
  logic [13:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 tck = ~tck;

  jtag_reg_access i_jtag_reg_access (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .pwr_ctl_o(pwr_ctl_o), .pwr_stat_i(pwr_stat_i),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // Bus responder with programmable latency
  int          lat = 0;
  int          cnt = 0;
  bit          pend = 0;
  int          n_req = 0;
  logic [13:0] last_addr = '0;
  logic        last_wr = 1'b0;
  logic [31:0] last_wdata = '0;

  always @(posedge tck) begin
    rsp_valid <= 1'b0;
    if (req_valid && req_ready && !pend) begin
      n_req      <= n_req + 1;
      last_addr  <= req_addr;
      last_wr    <= req_write;
      last_wdata <= req_wdata;
      pend       <= 1'b1;
      cnt        <= lat;
    end else if (pend) begin
      if (cnt == 0) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= 32'hC0DE0000 | {18'b0, last_addr};
        pend      <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o);
    @(negedge tck);
    tms = m;
    tdi = d;
    #1 o = tdo;
  endtask

  task automatic idle(input int n);
    logic o;
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, o);
  endtask

  task automatic scan_ir(input logic [4:0] code, output logic [4:0] cap);
    logic o;
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < 5; i++) begin
      tick(i == 4, code[i], o);
      cap[i] = o;
    end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  task automatic scan_dr(input int len, input logic [31:0] din, output logic [31:0] dout);
    logic o;
    dout = '0;
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < len; i++) begin
      tick(i == len - 1, din[i], o);
      dout[i] = o;
    end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  // Expected bus offset computed arithmetically; -1 marks a hole
  function automatic int exp_off(input int a);
    if (a < 32)              return a * 4;
    if (a < 64)              return 4096 + (a % 8) * 4 + ((a / 8) % 4) * 128;
    if (a < 80)              return 8192 + (a % 16) * 4;
    if (a >= 88 && a < 96)   return 12288 + (a % 16) * 4;
    if (a == 96)             return 16128;
    if (a >= 104)            return 16256 + (a % 32) * 4;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R11 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [4:0]  ic;
    logic [31:0] d;
    logic [31:0] st;
    int          base;
    int          prev;
    repeat (3) @(posedge tck);
    @(negedge tck);
    trst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 reset pwr_ctl", 32'(pwr_ctl_o), 32'h0);
    chk("R1 reset req_valid", 32'(req_valid), 32'h0);

    // R3 IDCODE selected straight out of reset
    scan_dr(32, 32'h0, d);
    chk("R3 idcode after reset", d, 32'h120034E5);

    // R2 capture pattern and bypass selection
    scan_ir(5'h1F, ic);
    chk("R2 ir capture", 32'(ic), 32'h1);
    scan_dr(8, 32'hB6, d);
    chk("R4 bypass one-cycle delay", d & 32'hFF, (32'hB6 << 1) & 32'hFF);
    scan_ir(5'h05, ic);
    scan_dr(8, 32'h4D, d);
    chk("R2 unknown code acts as bypass", d & 32'hFF, (32'h4D << 1) & 32'hFF);

    // R12 power control and status
    scan_ir(5'h08, ic);
    scan_dr(8, 32'hA5, d);
    chk("R12 pwr ctl capture initial", d & 32'hFF, 32'h0);
    idle(1);
    chk("R12 pwr ctl update", 32'(pwr_ctl_o), 32'hA5);
    scan_dr(8, 32'h3C, d);
    chk("R12 pwr ctl capture current", d & 32'hFF, 32'hA5);
    pwr_stat_i = 8'h5E;
    base = n_req;
    scan_ir(5'h09, ic);
    scan_dr(8, 32'hFF, d);
    idle(2);
    chk("R12 pwr stat capture", d & 32'hFF, 32'h5E);
    chk("R12 pwr stat update no effect on ctl", 32'(pwr_ctl_o), 32'h3C);
    chk("R12 pwr stat update no request", n_req, base);

    // R1 TMS reset restores IDCODE and clears power control
    begin
      logic o;
      for (int i = 0; i < 5; i++) tick(1, 0, o);
      tick(0, 0, o);
    end
    chk("R1 tlr clears pwr ctl", 32'(pwr_ctl_o), 32'h0);
    scan_dr(32, 32'h0, d);
    chk("R1 tlr reloads idcode", d, 32'h120034E5);

    // R5..R8 sweep every compact address as a read
    scan_ir(5'h1C, ic);
    prev = 0;
    for (int a = 0; a < 128; a++) begin
      lat  = a % 4;
      base = n_req;
      scan_dr(8, 32'(a << 1), st);
      if (a > 0)
        chk($sformatf("R5 R10 status before addr %0d", a), st & 32'hFF,
            (exp_off(prev) < 0) ? 32'h1 : 32'h0);
      idle(8);
      if (exp_off(a) < 0) begin
        chk($sformatf("R7 hole %0d no request", a), n_req, base);
      end else begin
        chk($sformatf("R8 addr %0d one read", a), n_req, base + 1);
        chk($sformatf("R6 addr %0d offset", a), 32'(last_addr), 32'(exp_off(a)));
        chk($sformatf("R8 addr %0d direction", a), 32'(last_wr), 32'h0);
      end
      scan_dr(32, 32'h0, d);
      if (exp_off(a) >= 0)
        chk($sformatf("R8 addr %0d read data", a), d, 32'hC0DE0000 | 32'(exp_off(a)));
      prev = a;
    end

    // R9 write: command alone issues nothing, data update writes
    lat  = 1;
    base = n_req;
    scan_dr(8, (32'h45 << 1) | 32'h1, st);
    idle(4);
    chk("R9 write command alone no request", n_req, base);
    scan_dr(32, 32'hDEADBEEF, d);
    idle(6);
    chk("R9 write issued", n_req, base + 1);
    chk("R9 write direction", 32'(last_wr), 32'h1);
    chk("R9 write data", last_wdata, 32'hDEADBEEF);
    chk("R9 write offset", 32'(last_addr), 32'h2014);
    scan_dr(8, (32'h45 << 1) | 32'h1, st);
    scan_dr(32, 32'h0BADF00D, d);
    idle(6);
    chk("R9 second data update writes again", n_req, base + 2);
    chk("R9 second write data", last_wdata, 32'h0BADF00D);

    // R10 command while busy
    lat  = 150;
    base = n_req;
    scan_ir(5'h1C, ic);
    scan_dr(8, 32'h10 << 1, st);
    idle(2);
    scan_ir(5'h1C, ic);
    scan_dr(8, 32'h11 << 1, st);
    chk("R10 busy visible in capture", st & 32'hFF, 32'h2);
    idle(2);
    chk("R10 busy command ignored", n_req, base + 1);
    scan_ir(5'h1C, ic);
    scan_dr(8, 32'h12 << 1, st);
    chk("R10 busy and error", st & 32'hFF, 32'h3);
    idle(200);
    scan_ir(5'h1C, ic);
    scan_dr(8, 32'h13 << 1, st);
    chk("R10 error held after response", st & 32'hFF, 32'h1);
    idle(200);
    chk("R10 accepted after response", n_req, base + 2);
    chk("R6 offset 0x13", 32'(last_addr), 32'h4C);
    scan_dr(32, 32'h0, d);
    chk("R8 delayed read data", d, 32'hC0DE004C);
    scan_dr(8, 32'h13 << 1, st);
    chk("R10 error cleared", st & 32'hFF, 32'h0);
    idle(200);

    // R10 write while busy
    base = n_req;
    scan_ir(5'h1C, ic);
    scan_dr(8, (32'h45 << 1) | 32'h1, st);
    scan_dr(32, 32'h11111111, d);
    idle(2);
    scan_dr(8, (32'h46 << 1) | 32'h1, st);
    chk("R10 busy after write", st & 32'hFF, 32'h2);
    scan_dr(32, 32'h22222222, d);
    idle(2);
    chk("R10 busy write ignored", n_req, base + 1);
    chk("R10 pending write data kept", req_wdata === 32'h11111111 ? 32'h1 : 32'h0, 32'h1);
    idle(200);
    chk("R10 completed write data", last_wdata, 32'h11111111);
    chk("R10 completed write offset", 32'(last_addr), 32'h2014);

    // R11 request held under back-pressure
    lat  = 0;
    base = n_req;
    req_ready = 1'b0;
    scan_ir(5'h1C, ic);
    scan_dr(8, 32'h7F << 1, st);
    idle(5);
    chk("R11 valid held", 32'(req_valid), 32'h1);
    chk("R11 addr held", 32'(req_addr), 32'h3FFC);
    idle(3);
    chk("R11 still held", 32'(req_valid), 32'h1);
    chk("R11 no handshake while stalled", n_req, base);
    @(negedge tck);
    req_ready = 1'b1;
    idle(10);
    chk("R11 accepted once", n_req, base + 1);
    chk("R11 req dropped", 32'(req_valid), 32'h0);
    scan_dr(32, 32'h0, d);
    chk("R8 stalled read data", d, 32'hC0DE3FFC);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule